// File: doc/BRIEF.md
# Debug Register Access Bridge

This block sits between a debug interconnect that speaks in 16-bit register reads and writes and the debug-unit port of a CPU core, which has a 16-bit register address, a write enable and 32-bit data in each direction. The core port reaches every core register, special-purpose ones included, so the bridge needs no other path into the core.

Each 32-bit core register is presented to the debug side as a pair of 16-bit registers in a directly mapped window. A second, indirect window is made of an address register and two data registers. Every request gets exactly one response, and a 32-bit value always takes two independent request/response exchanges. The low half of a write is held back until the high half arrives, so the core never receives a half-updated value. A low-half read fetches and keeps the full word, so the matching high-half read needs no second core access.

Top module: `dbg_reg_bridge`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `core_req` is 0.
- R2: One request is handled at a time. `req_ready` is 0 from the cycle after acceptance until the cycle after the response is taken (`rsp_valid && rsp_ready`). Each accepted request produces exactly one response, and that response holds stable while it is stalled.
- R3: In the direct window, debug address A with DIR_BASE (0x0400) ≤ A selects core register index (A − DIR_BASE) >> 1. Bit 0 of (A − DIR_BASE) selects the low half (0, bits 15:0) or the high half (1, bits 31:16). Valid indices are 0 to DIR_REGS−1, with DIR_REGS defaulting to 4096.
- R4: A direct low-half write only stages its data and makes no core access. A direct high-half write issues one core write of {high data, staged low} to that index.
- R5: A direct low-half read issues one core read, returns bits 15:0 and keeps the whole word. A following high-half read of the same index returns bits 31:16 of the kept word without a core access.
- R6: A direct high-half read with no kept word for that index issues a core read and returns bits 31:16. Any core write discards the kept word.
- R7: The indirect window sits at fixed offsets from IND_BASE (0x0200). Address +0 is a read/write core address register. Address +1 as a write stages the low data; as a read it issues a core read at the stored address and returns bits 15:0. Address +2 as a write issues a core write of {data, staged low} at the stored address; as a read it returns bits 31:16 of the last indirect core read (0 after reset) without a core access. Accesses at +0 and writes at +1 make no core access.
- R8: A core access raises `core_req` with `core_addr`, `core_we` and `core_wdata`, and holds all of them stable until `core_ack` is sampled high. A read drives `core_we` low.
- R9: The response is valid in the cycle after the clock edge that samples `core_ack`. For a request needing no core access, it is valid in the cycle after acceptance.
- R10: Addresses below IND_BASE, IND_BASE+3 up to DIR_BASE−1, and direct addresses whose index is DIR_REGS or more get a response with `rsp_error` = 1 and no core access.
- R11: Write responses and error responses carry `rsp_rdata` = 0. Every non-error response has `rsp_error` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Debug request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Debug register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_error | output | 1 | Request could not be mapped |
| rsp_rdata | output | 16 | Read data (0 for writes and errors) |
| core_req | output | 1 | Core access request |
| core_ack | input | 1 | Core access complete |
| core_we | output | 1 | Core write enable |
| core_addr | output | 16 | Core register address |
| core_wdata | output | 32 | Core write data |
| core_rdata | input | 32 | Core read data, valid with ack |

## Verification
A request that is answered locally gives `rsp_valid` in the cycle after the accepting edge, so the driver samples it at the very next falling edge. A request that goes to the core gives `core_req` after the accepting edge, and the response follows one cycle after the edge that samples `core_ack`. The core model therefore checks `rsp_valid` at the falling edge after the one where it raised the acknowledge. The scoreboard compares each response when it is consumed, and the driver counts core accesses between acceptance and the return of `req_ready` to prove that an access did or did not happen.

// File: rtl/dbg_bridge_pkg.sv
`timescale 1ns/1ps
package dbg_bridge_pkg;

    localparam int ADDR_W = 16;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    // Which window a debug address falls in
    typedef enum logic [2:0] {
        WIN_ERR,
        WIN_DIR_LO,
        WIN_DIR_HI,
        WIN_IND_ADDR,
        WIN_IND_LO,
        WIN_IND_HI
    } win_e;

    typedef struct packed {
        win_e              win;
        logic [ADDR_W-1:0] idx;
    } dec_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } core_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CORE,
        ST_RESP
    } st_e;

    function automatic logic [HALF_W-1:0] pick_half(input logic [WORD_W-1:0] w, input logic hi);
        return hi ? w[WORD_W-1 -: HALF_W] : w[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/dbg_addr_decode.sv
`timescale 1ns/1ps
module dbg_addr_decode
    import dbg_bridge_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IND_BASE = 16'h0200,
    parameter logic [ADDR_W-1:0] DIR_BASE = 16'h0400,
    parameter int unsigned       DIR_REGS = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int LW = ADDR_W + 1;
    localparam logic [LW-1:0] REG_LIMIT = LW'(DIR_REGS);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off     = addr - DIR_BASE;
        dec.win = WIN_ERR;
        dec.idx = '0;
        if (addr >= DIR_BASE) begin
            if ({2'b00, off[ADDR_W-1:1]} < REG_LIMIT) begin
                dec.idx = {1'b0, off[ADDR_W-1:1]};
                dec.win = off[0] ? WIN_DIR_HI : WIN_DIR_LO;
            end
        end else if (addr == IND_BASE) begin
            dec.win = WIN_IND_ADDR;
        end else if (addr == IND_BASE + 16'd1) begin
            dec.win = WIN_IND_LO;
        end else if (addr == IND_BASE + 16'd2) begin
            dec.win = WIN_IND_HI;
        end
    end

endmodule

// File: rtl/dbg_core_port.sv
`timescale 1ns/1ps
module dbg_core_port
    import dbg_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  core_cmd_t         cmd,
    output logic              done,
    output logic              core_req,
    input  logic              core_ack,
    output logic              core_we,
    output logic [ADDR_W-1:0] core_addr,
    output logic [WORD_W-1:0] core_wdata
);
    core_cmd_t cmd_q;
    logic      req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            cmd_q <= '0;
        end else if (!req_q && start) begin
            req_q <= 1'b1;
            cmd_q <= cmd;
        end else if (req_q && core_ack) begin
            req_q <= 1'b0;
        end
    end

    assign done       = req_q && core_ack;
    assign core_req   = req_q;
    assign core_we    = cmd_q.we;
    assign core_addr  = cmd_q.addr;
    assign core_wdata = cmd_q.wdata;

    // R8: request fields frozen until the core acknowledges
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        core_req && !core_ack |=> core_req && $stable(core_addr) && $stable(core_we) && $stable(core_wdata));

endmodule

// File: rtl/dbg_reg_bridge.sv
`timescale 1ns/1ps
module dbg_reg_bridge
    import dbg_bridge_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IND_BASE = 16'h0200,
    parameter logic [ADDR_W-1:0] DIR_BASE = 16'h0400,
    parameter int unsigned       DIR_REGS = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [HALF_W-1:0] req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_error,
    output logic [HALF_W-1:0] rsp_rdata,
    output logic              core_req,
    input  logic              core_ack,
    output logic              core_we,
    output logic [ADDR_W-1:0] core_addr,
    output logic [WORD_W-1:0] core_wdata,
    input  logic [WORD_W-1:0] core_rdata
);
    st_e               st;
    dec_t              dec;
    logic              acc;
    logic              done;

    // Staging and kept-word state
    logic [HALF_W-1:0] stage_lo;
    logic [WORD_W-1:0] keep_word;
    logic [ADDR_W-1:0] keep_idx;
    logic              keep_ok;
    logic [ADDR_W-1:0] ind_addr;
    logic [HALF_W-1:0] ind_wlo;
    logic [WORD_W-1:0] ind_rword;
    logic              pend_hi;
    logic              pend_ind;
    logic              err_q;
    logic [HALF_W-1:0] data_q;

    // Per-request decisions
    logic              start;
    core_cmd_t         cmd;
    logic              loc_err;
    logic [HALF_W-1:0] loc_data;
    logic              p_hi;
    logic              p_ind;
    logic              set_stage;
    logic              set_iaddr;
    logic              set_iwlo;

    dbg_addr_decode #(
        .IND_BASE (IND_BASE),
        .DIR_BASE (DIR_BASE),
        .DIR_REGS (DIR_REGS)
    ) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    dbg_core_port u_port (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmd        (cmd),
        .done       (done),
        .core_req   (core_req),
        .core_ack   (core_ack),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (core_wdata)
    );

    assign acc       = req_valid && (st == ST_IDLE);
    assign req_ready = (st == ST_IDLE);
    assign rsp_valid = (st == ST_RESP);
    assign rsp_error = err_q;
    assign rsp_rdata = data_q;

    always_comb begin
        start     = 1'b0;
        cmd       = '0;
        loc_err   = 1'b0;
        loc_data  = '0;
        p_hi      = 1'b0;
        p_ind     = 1'b0;
        set_stage = 1'b0;
        set_iaddr = 1'b0;
        set_iwlo  = 1'b0;
        if (acc) begin
            unique case (dec.win)
                WIN_DIR_LO: begin
                    if (req_write) begin
                        set_stage = 1'b1;
                    end else begin
                        start    = 1'b1;
                        cmd.addr = dec.idx;
                    end
                end
                WIN_DIR_HI: begin
                    if (req_write) begin
                        start     = 1'b1;
                        cmd.we    = 1'b1;
                        cmd.addr  = dec.idx;
                        cmd.wdata = {req_wdata, stage_lo};
                    end else if (keep_ok && keep_idx == dec.idx) begin
                        loc_data = pick_half(keep_word, 1'b1);
                    end else begin
                        start    = 1'b1;
                        cmd.addr = dec.idx;
                        p_hi     = 1'b1;
                    end
                end
                WIN_IND_ADDR: begin
                    if (req_write) set_iaddr = 1'b1;
                    else           loc_data  = ind_addr;
                end
                WIN_IND_LO: begin
                    if (req_write) begin
                        set_iwlo = 1'b1;
                    end else begin
                        start    = 1'b1;
                        cmd.addr = ind_addr;
                        p_ind    = 1'b1;
                    end
                end
                WIN_IND_HI: begin
                    if (req_write) begin
                        start     = 1'b1;
                        cmd.we    = 1'b1;
                        cmd.addr  = ind_addr;
                        cmd.wdata = {req_wdata, ind_wlo};
                    end else begin
                        loc_data = pick_half(ind_rword, 1'b1);
                    end
                end
                default: loc_err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            err_q     <= 1'b0;
            data_q    <= '0;
            stage_lo  <= '0;
            keep_word <= '0;
            keep_idx  <= '0;
            keep_ok   <= 1'b0;
            ind_addr  <= '0;
            ind_wlo   <= '0;
            ind_rword <= '0;
            pend_hi   <= 1'b0;
            pend_ind  <= 1'b0;
        end else begin
            if (set_stage) stage_lo <= req_wdata;
            if (set_iaddr) ind_addr <= req_wdata;
            if (set_iwlo)  ind_wlo  <= req_wdata;
            unique case (st)
                ST_IDLE: begin
                    if (acc) begin
                        if (start) begin
                            st       <= ST_CORE;
                            pend_hi  <= p_hi;
                            pend_ind <= p_ind;
                        end else begin
                            st     <= ST_RESP;
                            err_q  <= loc_err;
                            data_q <= loc_data;
                        end
                    end
                end
                ST_CORE: begin
                    if (done) begin
                        st    <= ST_RESP;
                        err_q <= 1'b0;
                        if (core_we) begin
                            data_q  <= '0;
                            keep_ok <= 1'b0;
                        end else begin
                            data_q <= pick_half(core_rdata, pend_hi);
                            if (pend_ind) begin
                                ind_rword <= core_rdata;
                            end else begin
                                keep_word <= core_rdata;
                                keep_idx  <= core_addr;
                                keep_ok   <= 1'b1;
                            end
                        end
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9: response follows the core acknowledge by one cycle
    a_r9_rsp_after_ack: assert property (@(posedge clk) disable iff (rst)
        core_req && core_ack |=> rsp_valid && !rsp_error);

    // R2: a stalled response keeps its contents
    a_r2_rsp_hold: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_error));

    // R2: no acceptance while a core access is in flight
    a_r2_no_accept: assert property (@(posedge clk) disable iff (rst)
        core_req |-> !req_ready && !rsp_valid);

    // R10: low base-register addresses give an error and leave the core idle
    a_r10_base_err: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (req_addr < IND_BASE) |=> rsp_valid && rsp_error && !core_req);

    // R11: error responses carry zero data
    a_r11_err_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_error |-> rsp_rdata == '0);

endmodule

// File: tb/dbg_reg_bridge_tb.sv
`timescale 1ns/1ps
module dbg_reg_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_error;
    logic [15:0] rsp_rdata;
    logic        core_req;
    logic        core_ack = 1'b0;
    logic        core_we;
    logic [15:0] core_addr;
    logic [31:0] core_wdata;
    logic [31:0] core_rdata = '0;

    always #4 clk = ~clk;

    dbg_reg_bridge dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_error  (rsp_error),
        .rsp_rdata  (rsp_rdata),
        .core_req   (core_req),
        .core_ack   (core_ack),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .core_rdata (core_rdata)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done_f = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- core model ----------------
    logic [31:0] mem [64];
    int          core_cnt = 0;
    bit          busy = 1'b0;
    int          wait_n = 0;
    logic        h_we;
    logic [15:0] h_addr;
    logic [31:0] h_wd;

    always @(negedge clk) begin
        if (!rst) begin
            if (core_ack) begin
                core_ack = 1'b0;
                chk(rsp_valid == 1'b1, "R9 response one cycle after ack", 32'(rsp_valid), 32'd1);
            end else if (core_req) begin
                if (!busy) begin
                    busy   = 1'b1;
                    h_we   = core_we;
                    h_addr = core_addr;
                    h_wd   = core_wdata;
                    wait_n = core_cnt % 3;
                end else begin
                    chk(core_we == h_we && core_addr == h_addr && core_wdata == h_wd,
                        "R8 core request held stable", {16'h0, core_addr}, {16'h0, h_addr});
                end
                if (wait_n == 0) begin
                    core_ack = 1'b1;
                    if (h_we) mem[h_addr[5:0]] = h_wd;
                    else      core_rdata = mem[h_addr[5:0]];
                    core_cnt++;
                    busy = 1'b0;
                end else begin
                    wait_n--;
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic        err;
        logic [15:0] data;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    int   stall_n = 0;

    always @(negedge clk) begin
        if (!rst) begin
            rsp_ready = (stall_n % 5) != 2;
            stall_n++;
            if (rsp_valid && rsp_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 response without request", {16'h0, rsp_rdata}, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(rsp_error == e.err && rsp_rdata == e.data, e.tag,
                        {15'h0, rsp_error, rsp_rdata}, {15'h0, e.err, e.data});
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic xfer(input bit wr, input logic [15:0] a, input logic [15:0] wd,
                        input bit e_err, input logic [15:0] e_data, input int e_core, input string tag);
        int   c0;
        exp_t e;
        do @(negedge clk); while (!req_ready);
        c0        = core_cnt;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        e.err     = e_err;
        e.data    = e_data;
        e.tag     = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {"R2 busy after accept: ", tag}, 32'(req_ready), 32'd0);
        if (e_core == 0)
            chk(rsp_valid == 1'b1, {"R9 local response next cycle: ", tag}, 32'(rsp_valid), 32'd1);
        do @(negedge clk); while (!req_ready);
        chk(core_cnt - c0 == e_core, {"core access count: ", tag}, 32'(core_cnt - c0), 32'(e_core));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = (32'(i) + 32'd1) * 32'h9E37_79B9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && core_req == 1'b0, "R1 reset state",
            {29'h0, req_ready, rsp_valid, core_req}, 32'h4);

        // R3 R5: direct low read of index 5, then the high half from the kept word
        xfer(0, 16'h040A, 16'h0, 0, mem[5][15:0], 1, "R3 R5 direct low read idx5");
        xfer(0, 16'h040B, 16'h0, 0, mem[5][31:16], 0, "R5 direct high read from kept word");
        // R6: high read with no kept word
        xfer(0, 16'h040F, 16'h0, 0, mem[7][31:16], 1, "R6 direct high read miss idx7");
        // R4: staged low write, then high write combines
        xfer(1, 16'h0404, 16'h1234, 0, 16'h0, 0, "R4 R11 direct low write staged");
        chk(mem[2] == (32'd3 * 32'h9E37_79B9), "R4 core untouched after low write", mem[2], 32'd3 * 32'h9E37_79B9);
        xfer(1, 16'h0405, 16'hABCD, 0, 16'h0, 1, "R4 R11 direct high write");
        chk(mem[2] == 32'hABCD_1234, "R4 core word combined", mem[2], 32'hABCD_1234);
        // R6: the core write discarded the kept word for index 7
        xfer(0, 16'h040F, 16'h0, 0, mem[7][31:16], 1, "R6 kept word dropped after write");
        // R3: largest valid direct index maps to core address 0x0FFF
        xfer(0, 16'h23FE, 16'h0, 0, mem[63][15:0], 1, "R3 top direct index low read");

        // R7: indirect window
        xfer(1, 16'h0200, 16'h0021, 0, 16'h0, 0, "R7 indirect address write");
        xfer(0, 16'h0200, 16'h0, 0, 16'h0021, 0, "R7 indirect address read back");
        xfer(0, 16'h0202, 16'h0, 0, 16'h0000, 0, "R7 indirect high read before any fetch");
        xfer(1, 16'h0201, 16'h5555, 0, 16'h0, 0, "R7 indirect low write staged");
        chk(mem[33] == (32'd34 * 32'h9E37_79B9), "R7 core untouched after indirect low", mem[33], 32'd34 * 32'h9E37_79B9);
        xfer(1, 16'h0202, 16'h6666, 0, 16'h0, 1, "R7 indirect high write");
        chk(mem[33] == 32'h6666_5555, "R7 indirect word combined", mem[33], 32'h6666_5555);
        xfer(0, 16'h0201, 16'h0, 0, 16'h5555, 1, "R7 indirect low read");
        xfer(0, 16'h0202, 16'h0, 0, 16'h6666, 0, "R7 indirect high read from fetched word");

        // R10 R11: unmapped addresses
        xfer(0, 16'h0010, 16'h0, 1, 16'h0, 0, "R10 base register range");
        xfer(1, 16'h0203, 16'hFFFF, 1, 16'h0, 0, "R10 gap after indirect window");
        xfer(0, 16'h03FF, 16'h0, 1, 16'h0, 0, "R10 gap below direct window");
        xfer(0, 16'h2400, 16'h0, 1, 16'h0, 0, "R10 direct index past limit");
        xfer(1, 16'h2401, 16'h7777, 1, 16'h0, 0, "R10 direct write past limit");
        chk(exp_q.size() == 0, "R2 every request answered", 32'(exp_q.size()), 32'd0);

        if (!done_f) begin
            done_f = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done_f) begin
            done_f = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule